// File: doc/BRIEF.md
# Parallel Multi-Input Maximum Selector

This block accepts a set of unsigned operands of equal width in a single cycle. One registered cycle later it returns the largest operand and the position of the operand that holds it. All operands arrive together on one flat bus. When the caller raises `in_valid`, the result appears in the following cycle and is flagged by `out_valid`. On cycles without `in_valid`, the result registers keep their last contents.

The winner logic comes in three architectures, chosen at elaboration time. The default architecture compares every unordered pair of operands at the same moment and merges the pairwise outcomes into a one-hot winner vector. This keeps the depth near log(width) + log(count). The second architecture is a balanced tree of two-input comparators. It is cheaper in area but has depth near log(width) × log(count). The third architecture scans bit columns from the most significant bit down and drops the candidates that are beaten in each column. In every architecture the one-hot winner vector feeds a shared AND-OR multiplexer and an index encoder.

Top module: `maxsel_top`

## Requirements
- R1: While `rst_n` is low, and until the first accepted operand set, `out_valid`, `max_value` and `max_index` are all 0.
- R2: `out_valid` is 1 in exactly those cycles that follow a clock edge at which `in_valid` was sampled high.
- R3: After an accepted operand set, `max_value` equals the largest operand, compared as unsigned numbers.
- R4: `max_index` names the operand that holds the maximum. When several operands share the maximum, the lowest index wins.
- R5: A clock edge at which `in_valid` is low leaves `max_value` and `max_index` unchanged, whatever the operand bus carries.
- R6: Operand i sits at bits [i*N_BITS +: N_BITS] of `operands`. Operand 0 sits in the least significant bits.
- R7: With ARCH = ARCH_ALLPAIRS, operand i wins when it is greater than or equal to every higher-indexed operand and strictly greater than every lower-indexed operand. This takes K_IN(K_IN-1)/2 comparators and yields exactly one winner.
- R8: With ARCH = ARCH_TREE, a comparator tree gives the same value and index as R3 and R4 for every input. At each tree node the upper half wins only when it is strictly greater.
- R9: With ARCH = ARCH_COLUMN, the column scan gives the same value and index as R3 and R4 for every input. A column in which no surviving candidate has a 1 eliminates nobody. A column in which any survivor has a 1 drops every survivor that has a 0 there.
- R10: With eight-bit operands 22, 59, 62, 61 in positions 0 to 3, the result is value 62 at index 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand bus holds a set to evaluate this cycle |
| operands | input | K_IN*N_BITS | Flat operand bus, operand i at [i*N_BITS +: N_BITS] |
| out_valid | output | 1 | Result registers were loaded on the previous edge |
| max_value | output | N_BITS | Largest operand of the last accepted set |
| max_index | output | IDX_W | Position of that operand, lowest on ties |

## Verification
The bench sweeps every operand combination of a three-bit, four-input configuration through all three architectures. Ties and all-zero columns therefore occur in bulk. A tie rule that favours the higher index, or an `>=` where `>` belongs, shows up as a wrong index or as two winners OR-ed into a garbage value. A column scan that eliminates on an all-zero column shows up as a zero or corrupted result. A five-input eight-bit configuration then checks padding of the tree to a power of two, a lone maximum at every position, all-equal, all-zero and all-ones sets, and the worked example. A register that loads without `in_valid` fails the hold check.

// File: rtl/maxsel_pkg.sv
package maxsel_pkg;

    typedef enum logic [1:0] {
        ARCH_ALLPAIRS = 2'd0,
        ARCH_TREE     = 2'd1,
        ARCH_COLUMN   = 2'd2
    } maxsel_arch_e;

    // Flat slot of the comparator for the unordered pair (i, j), i < j.
    function automatic int pair_slot(input int k, input int i, input int j);
        return i * k - (i * (i + 1)) / 2 + (j - i - 1);
    endfunction

endpackage

// File: rtl/maxsel_allpairs.sv
module maxsel_allpairs
    import maxsel_pkg::*;
#(
    parameter int N_BITS = 8,
    parameter int K_IN   = 4
) (
    input  logic [K_IN*N_BITS-1:0] operands,
    output logic [K_IN-1:0]        win
);
    localparam int PAIRS = K_IN * (K_IN - 1) / 2;

    // ge_bus[slot(i,j)] = operand i >= operand j, for i < j only.
    logic [PAIRS-1:0] ge_bus;

    for (genvar gi = 0; gi < K_IN; gi++) begin : g_row
        for (genvar gj = gi + 1; gj < K_IN; gj++) begin : g_col
            localparam int SLOT = pair_slot(K_IN, gi, gj);
            assign ge_bus[SLOT] = operands[gi*N_BITS +: N_BITS] >= operands[gj*N_BITS +: N_BITS];
        end
    end

    // R7: >= against higher indices, strict > against lower indices.
    always_comb begin
        for (int i = 0; i < K_IN; i++) begin
            win[i] = 1'b1;
            for (int j = 0; j < K_IN; j++) begin
                if (j > i)
                    win[i] = win[i] & ge_bus[pair_slot(K_IN, i, j)];
                else if (j < i)
                    win[i] = win[i] & ~ge_bus[pair_slot(K_IN, j, i)];
            end
        end
    end

endmodule

// File: rtl/maxsel_tree.sv
module maxsel_tree #(
    parameter int N_BITS = 8,
    parameter int K_IN   = 4
) (
    input  logic [K_IN*N_BITS-1:0] operands,
    output logic [K_IN-1:0]        win
);
    localparam int PAD_W = (K_IN > 1) ? $clog2(K_IN) : 1;
    localparam int K_PAD = 1 << PAD_W;
    localparam int NODES = 2 * K_PAD - 1;

    // Heap layout: node n (1-based) at slot n-1, leaves at K_PAD..2*K_PAD-1.
    logic [N_BITS-1:0] node_val [NODES];
    logic [PAD_W-1:0]  node_idx [NODES];
    logic              node_ok  [NODES];
    logic              take_hi;

    always_comb begin
        take_hi = 1'b0;
        for (int i = 0; i < K_IN; i++) begin
            node_val[K_PAD + i - 1] = operands[i*N_BITS +: N_BITS];
            node_idx[K_PAD + i - 1] = PAD_W'(i);
            node_ok [K_PAD + i - 1] = 1'b1;
        end
        for (int i = K_IN; i < K_PAD; i++) begin
            node_val[K_PAD + i - 1] = '0;
            node_idx[K_PAD + i - 1] = PAD_W'(i);
            node_ok [K_PAD + i - 1] = 1'b0;
        end
        // R8: upper half replaces lower half only when strictly greater.
        for (int n = K_PAD - 1; n >= 1; n--) begin
            take_hi = node_ok[2*n] &&
                      (!node_ok[2*n - 1] || (node_val[2*n] > node_val[2*n - 1]));
            node_val[n-1] = take_hi ? node_val[2*n] : node_val[2*n - 1];
            node_idx[n-1] = take_hi ? node_idx[2*n] : node_idx[2*n - 1];
            node_ok [n-1] = node_ok[2*n] | node_ok[2*n - 1];
        end
    end

    always_comb begin
        for (int i = 0; i < K_IN; i++)
            win[i] = (node_idx[0] == PAD_W'(i));
    end

endmodule

// File: rtl/maxsel_column.sv
module maxsel_column #(
    parameter int N_BITS = 8,
    parameter int K_IN   = 4
) (
    input  logic [K_IN*N_BITS-1:0] operands,
    output logic [K_IN-1:0]        win
);
    logic [K_IN-1:0] alive;
    logic [K_IN-1:0] column;
    logic [K_IN-1:0] hits;

    // R9: walk from MSB; a column with no surviving 1 removes nobody.
    always_comb begin
        alive  = '1;
        column = '0;
        hits   = '0;
        for (int b = N_BITS - 1; b >= 0; b--) begin
            for (int i = 0; i < K_IN; i++)
                column[i] = operands[i*N_BITS + b];
            hits = alive & column;
            if (hits != '0)
                alive = hits;
        end
        // Survivors are all equal; keep the lowest-index one (R4).
        win = alive & (~alive + K_IN'(1));
    end

endmodule

// File: rtl/maxsel_mux.sv
module maxsel_mux #(
    parameter int N_BITS = 8,
    parameter int K_IN   = 4,
    parameter int IDX_W  = 2
) (
    input  logic [K_IN*N_BITS-1:0] operands,
    input  logic [K_IN-1:0]        win,
    output logic [N_BITS-1:0]      sel_value,
    output logic [IDX_W-1:0]       sel_index
);
    always_comb begin
        sel_value = '0;
        sel_index = '0;
        for (int i = 0; i < K_IN; i++) begin
            sel_value = sel_value | ({N_BITS{win[i]}} & operands[i*N_BITS +: N_BITS]);
            if (win[i])
                sel_index = sel_index | IDX_W'(i);
        end
    end

endmodule

// File: rtl/maxsel_top.sv
module maxsel_top
    import maxsel_pkg::*;
#(
    parameter int           N_BITS = 8,
    parameter int           K_IN   = 4,
    parameter maxsel_arch_e ARCH   = ARCH_ALLPAIRS,
    localparam int          IDX_W  = (K_IN > 1) ? $clog2(K_IN) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [K_IN*N_BITS-1:0] operands,
    output logic                   out_valid,
    output logic [N_BITS-1:0]      max_value,
    output logic [IDX_W-1:0]       max_index
);
    logic [K_IN-1:0]   win;
    logic [N_BITS-1:0] sel_value;
    logic [IDX_W-1:0]  sel_index;

    if (ARCH == ARCH_ALLPAIRS) begin : g_allpairs
        maxsel_allpairs #(.N_BITS(N_BITS), .K_IN(K_IN)) u_core (
            .operands(operands), .win(win));
    end else if (ARCH == ARCH_TREE) begin : g_tree
        maxsel_tree #(.N_BITS(N_BITS), .K_IN(K_IN)) u_core (
            .operands(operands), .win(win));
    end else begin : g_column
        maxsel_column #(.N_BITS(N_BITS), .K_IN(K_IN)) u_core (
            .operands(operands), .win(win));
    end

    maxsel_mux #(.N_BITS(N_BITS), .K_IN(K_IN), .IDX_W(IDX_W)) u_mux (
        .operands (operands),
        .win      (win),
        .sel_value(sel_value),
        .sel_index(sel_index)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            max_value <= '0;
            max_index <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                max_value <= sel_value;
                max_index <= sel_index;
            end
        end
    end

    a_r7_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ($countones(win) == 1));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r5_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(max_value) && $stable(max_index)));

    a_r4_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(max_index) < K_IN));

    for (genvar gi = 0; gi < K_IN; gi++) begin : g_dom
        a_r3_dominates: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> (sel_value >= operands[gi*N_BITS +: N_BITS]));
    end

endmodule

// File: tb/maxsel_top_test.sv
module maxsel_top_test;
    import maxsel_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NA = 8;
    localparam int KA = 5;
    localparam int IA = 3;
    localparam int NB = 3;
    localparam int KB = 4;
    localparam int IB = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic              in_a = 1'b0;
    logic [KA*NA-1:0]  ops_a = '0;
    logic              vld_a [3];
    logic [NA-1:0]     val_a [3];
    logic [IA-1:0]     idx_a [3];

    logic              in_b = 1'b0;
    logic [KB*NB-1:0]  ops_b = '0;
    logic              vld_b [3];
    logic [NB-1:0]     val_b [3];
    logic [IB-1:0]     idx_b [3];

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    string arch_tag [3] = '{"R7", "R8", "R9"};

    maxsel_top #(.N_BITS(NA), .K_IN(KA), .ARCH(ARCH_ALLPAIRS)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_a), .operands(ops_a),
        .out_valid(vld_a[0]), .max_value(val_a[0]), .max_index(idx_a[0]));
    maxsel_top #(.N_BITS(NA), .K_IN(KA), .ARCH(ARCH_TREE)) uut_a_tree (
        .clk(clk), .rst_n(rst_n), .in_valid(in_a), .operands(ops_a),
        .out_valid(vld_a[1]), .max_value(val_a[1]), .max_index(idx_a[1]));
    maxsel_top #(.N_BITS(NA), .K_IN(KA), .ARCH(ARCH_COLUMN)) uut_a_col (
        .clk(clk), .rst_n(rst_n), .in_valid(in_a), .operands(ops_a),
        .out_valid(vld_a[2]), .max_value(val_a[2]), .max_index(idx_a[2]));
    maxsel_top #(.N_BITS(NB), .K_IN(KB), .ARCH(ARCH_ALLPAIRS)) uut_b_pair (
        .clk(clk), .rst_n(rst_n), .in_valid(in_b), .operands(ops_b),
        .out_valid(vld_b[0]), .max_value(val_b[0]), .max_index(idx_b[0]));
    maxsel_top #(.N_BITS(NB), .K_IN(KB), .ARCH(ARCH_TREE)) uut_b_tree (
        .clk(clk), .rst_n(rst_n), .in_valid(in_b), .operands(ops_b),
        .out_valid(vld_b[1]), .max_value(val_b[1]), .max_index(idx_b[1]));
    maxsel_top #(.N_BITS(NB), .K_IN(KB), .ARCH(ARCH_COLUMN)) uut_b_col (
        .clk(clk), .rst_n(rst_n), .in_valid(in_b), .operands(ops_b),
        .out_valid(vld_b[2]), .max_value(val_b[2]), .max_index(idx_b[2]));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Behavioural reference: largest unsigned value, lowest index on ties.
    task automatic ref_a(input logic [KA*NA-1:0] v, output int mv, output int mi);
        mv = -1; mi = 0;
        for (int i = 0; i < KA; i++)
            if (int'(v[i*NA +: NA]) > mv) begin mv = int'(v[i*NA +: NA]); mi = i; end
    endtask

    task automatic ref_b(input logic [KB*NB-1:0] v, output int mv, output int mi);
        mv = -1; mi = 0;
        for (int i = 0; i < KB; i++)
            if (int'(v[i*NB +: NB]) > mv) begin mv = int'(v[i*NB +: NB]); mi = i; end
    endtask

    task automatic run_a(input logic [KA*NA-1:0] v, input string req);
        int mv, mi;
        ops_a = v; in_a = 1'b1;
        ref_a(v, mv, mi);
        @(negedge clk);
        for (int a = 0; a < 3; a++) begin
            chk(vld_a[a] == 1'b1, {"R2 ", arch_tag[a]}, int'(vld_a[a]), 1);
            chk(int'(val_a[a]) == mv, {"R3 ", req, " ", arch_tag[a]}, int'(val_a[a]), mv);
            chk(int'(idx_a[a]) == mi, {"R4 ", req, " ", arch_tag[a]}, int'(idx_a[a]), mi);
        end
    endtask

    function automatic logic [KA*NA-1:0] pack5(input int a0, a1, a2, a3, a4);
        return {NA'(a4), NA'(a3), NA'(a2), NA'(a1), NA'(a0)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int mv, mi, prev_v, prev_i;
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 3; a++) begin
            chk(vld_a[a] == 1'b0 && val_a[a] == '0 && idx_a[a] == '0,
                {"R1 ", arch_tag[a]}, int'(val_a[a]) + int'(vld_a[a]), 0);
            chk(vld_b[a] == 1'b0 && val_b[a] == '0 && idx_b[a] == '0,
                {"R1 ", arch_tag[a]}, int'(val_b[a]) + int'(vld_b[a]), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 3; a++)
            chk(vld_a[a] == 1'b0, {"R2 idle ", arch_tag[a]}, int'(vld_a[a]), 0);

        // R10 / R6: worked example in positions 0..3
        run_a(pack5(22, 59, 62, 61, 0), "R10 R6 example");
        for (int a = 0; a < 3; a++)
            chk(val_a[a] == 8'd62 && idx_a[a] == 3'd2, {"R10 ", arch_tag[a]},
                int'(val_a[a]), 62);

        // R5: in_valid low, operands change, result must hold
        prev_v = int'(val_a[0]); prev_i = int'(idx_a[0]);
        in_a = 1'b0; ops_a = pack5(255, 1, 2, 3, 4);
        @(negedge clk);
        for (int a = 0; a < 3; a++) begin
            chk(vld_a[a] == 1'b0, {"R2 drop ", arch_tag[a]}, int'(vld_a[a]), 0);
            chk(int'(val_a[a]) == prev_v && int'(idx_a[a]) == prev_i,
                {"R5 hold ", arch_tag[a]}, int'(val_a[a]), prev_v);
        end

        run_a(pack5(85, 85, 85, 85, 85), "all equal");
        run_a(pack5(0, 0, 0, 0, 0), "all zero");
        run_a(pack5(255, 255, 255, 255, 255), "all ones");
        run_a(pack5(9, 200, 17, 200, 3), "tie two");
        for (int p = 0; p < KA; p++) begin
            logic [KA*NA-1:0] v;
            for (int i = 0; i < KA; i++) v[i*NA +: NA] = NA'(10 + 13 * i);
            v[p*NA +: NA] = 8'd180;
            run_a(v, "single max");
        end
        for (int n = 0; n < 2000; n++) begin
            logic [KA*NA-1:0] v;
            for (int i = 0; i < KA; i++) v[i*NA +: NA] = NA'($urandom_range(0, 255));
            if (n % 4 == 0) v[($urandom_range(0, KA-1))*NA +: NA] = v[NA-1:0];
            run_a(v, "random");
        end
        in_a = 1'b0;

        // Exhaustive sweep of the small configuration (R3, R4, R7, R8, R9)
        for (int n = 0; n < (1 << (KB*NB)); n++) begin
            ops_b = (KB*NB)'(n); in_b = 1'b1;
            ref_b(ops_b, mv, mi);
            @(negedge clk);
            for (int a = 0; a < 3; a++) begin
                chk(int'(val_b[a]) == mv, {"R3 sweep ", arch_tag[a]}, int'(val_b[a]), mv);
                chk(int'(idx_b[a]) == mi, {"R4 sweep ", arch_tag[a]}, int'(idx_b[a]), mi);
            end
        end
        in_b = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule